// File: doc/BRIEF.md
# Console Terminal I/O Transfer Controller

This block serves a console keyboard and printer for a processor with a 12-bit accumulator. The processor gives it every I/O transfer instruction word together with the current accumulator. The block decodes the instruction and keeps two flags: one that says a keyboard character is ready and one that says the printer has finished. One cycle after the instruction it returns a skip request and the new accumulator value. It can also send a byte to the printer, marked by a one-cycle strobe.

The low three bits of the instruction form an operation field. Each bit of that field starts one function, and the set bits act in order from bit 0 upward within a single instruction. Device 0 turns the interrupt system on and off. Turning it on takes effect only after the next instruction has completed. An interrupt request is raised while interrupts are on and either flag is set. The processor signals that it has taken an interrupt with an acknowledge pulse. The processor marks the end of every instruction that it does not pass to this block with a completion pulse.

Top module: `con_term_ctrl`

## Requirements
- R1: An instruction is acted on only when `iot_valid_i` is high and bits 11:9 of `iot_word_i` are 110. One cycle later `done_o` pulses and `acc_o` and `skip_o` carry the result. Any other word is ignored: `done_o` stays low and no state changes.
- R2: When operation bit 0 is set and the addressed device's flag is set, `skip_o` is 1. The flag value used is the one held before the instruction. The keyboard is device 3 (bits 8:3) and the printer is device 4.
- R3: For the keyboard, operation bit 1 clears the keyboard flag and clears the accumulator.
- R4: For the keyboard, operation bit 2 ORs the held input byte into accumulator bits 7:0 and leaves bits 11:8 unchanged. With code 110 the accumulator is cleared first and the byte is then loaded.
- R5: A pulse on `kbd_strobe_i` captures `kbd_char_i` and sets the keyboard flag. If a clear arrives in the same cycle, the new arrival wins.
- R6: For the printer, operation bit 2 pulses `prn_load_o` for one cycle, with `prn_byte_o` equal to accumulator bits 7:0. The accumulator is returned unchanged.
- R7: Only `prn_done_i` sets the printer flag. Operation bit 1 on the printer clears it. If a completion and a clear arrive in the same cycle, the completion wins.
- R8: Operation code 000 on any device, and any operation on a device other than 0, 3 or 4, leaves the flags unchanged. Such an instruction returns the accumulator unchanged with no skip.
- R9: Device 0 with operation 001 turns interrupts on. This takes effect at the next completion event after it, where a completion event is either a decoded instruction or an `instr_done_i` pulse.
- R10: Device 0 with operation 010 turns interrupts off at once and cancels any pending turn-on.
- R11: `irq_o` is high exactly while interrupts are on and at least one flag is set.
- R12: `int_ack_i` turns interrupts off and cancels any pending turn-on.
- R13: `mclr_i` clears both flags, turns interrupts off and cancels any pending turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclr_i | input | 1 | Master clear |
| iot_valid_i | input | 1 | Instruction present this cycle |
| iot_word_i | input | 12 | Instruction word |
| acc_i | input | 12 | Accumulator before the instruction |
| instr_done_i | input | 1 | Another instruction completed |
| int_ack_i | input | 1 | Interrupt taken |
| kbd_strobe_i | input | 1 | Keyboard character arrived |
| kbd_char_i | input | 8 | Arriving character |
| prn_done_i | input | 1 | Printer output completed |
| done_o | output | 1 | Result valid |
| skip_o | output | 1 | Skip request |
| acc_o | output | 12 | Accumulator after the instruction |
| prn_load_o | output | 1 | Printer byte strobe |
| prn_byte_o | output | 8 | Printer byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A flag stored wrongly shows up at the ports within one cycle, as a wrong `irq_o` while interrupts are on. Otherwise it appears at the next skip-test instruction to that device. A wrong held keyboard byte only appears when a read instruction runs. A turn-on pending state that is lost or set when it should not be changes `irq_o` on the cycle after the completion event that follows the turn-on instruction. The bench compares every output on every cycle against a behavioural model, so each of these faults is reported at the first cycle where it becomes visible.

// File: rtl/cterm_pkg.sv
package cterm_pkg;
  localparam int OP_W = 3;
  localparam logic [2:0] IOT_OPC = 3'b110;

  typedef struct packed {
    logic valid;
    logic kbd;
    logic prn;
    logic ion;
    logic iof;
    logic skp;
    logic clr;
    logic xfr;
  } cterm_dec_t;
endpackage

// File: rtl/cterm_decode.sv
module cterm_decode
  import cterm_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int DEV_W   = 6,
  parameter int KBD_DEV = 3,
  parameter int PRN_DEV = 4,
  parameter int INT_DEV = 0
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output cterm_dec_t        dec_o
);
  localparam int DEV_LO = OP_W;
  localparam int DEV_HI = OP_W + DEV_W - 1;

  logic [DEV_W-1:0] dev;
  logic [OP_W-1:0]  op;
  logic             hit;

  assign dev = word_i[DEV_HI:DEV_LO];
  assign op  = word_i[OP_W-1:0];
  assign hit = valid_i && (word_i[WORD_W-1:WORD_W-3] == IOT_OPC);

  always_comb begin
    dec_o       = '0;
    dec_o.valid = hit;
    dec_o.kbd   = hit && (dev == DEV_W'(KBD_DEV));
    dec_o.prn   = hit && (dev == DEV_W'(PRN_DEV));
    dec_o.ion   = hit && (dev == DEV_W'(INT_DEV)) && (op == 3'b001);
    dec_o.iof   = hit && (dev == DEV_W'(INT_DEV)) && (op == 3'b010);
    dec_o.skp   = op[0];
    dec_o.clr   = op[1];
    dec_o.xfr   = op[2];
  end
endmodule

// File: rtl/cterm_kbd.sv
module cterm_kbd #(
  parameter int WORD_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              sel_i,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic              flag_o,
  output logic [WORD_W-1:0] acc_o
);
  logic              flag_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (strobe_i) buf_q <= char_i;
      if (mclr_i)               flag_q <= 1'b0;
      else if (strobe_i)        flag_q <= 1'b1;
      else if (sel_i && clr_i)  flag_q <= 1'b0;
    end
  end

  always_comb begin
    acc_o = acc_i;
    if (sel_i && clr_i) acc_o = '0;
    if (sel_i && rd_i)  acc_o[DATA_W-1:0] = acc_o[DATA_W-1:0] | buf_q;
  end

  assign flag_o = flag_q;

  // R5
  kflag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(strobe_i));
endmodule

// File: rtl/cterm_prn.sv
module cterm_prn #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr_i,
  input  logic              done_i,
  input  logic              sel_i,
  input  logic              clr_i,
  input  logic              xfr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              flag_o,
  output logic              load_o,
  output logic [DATA_W-1:0] byte_o
);
  logic              flag_q;
  logic              load_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      load_q <= 1'b0;
      byte_q <= '0;
    end else begin
      load_q <= sel_i && xfr_i;
      if (sel_i && xfr_i) byte_q <= data_i;
      if (mclr_i)              flag_q <= 1'b0;
      else if (done_i)         flag_q <= 1'b1;
      else if (sel_i && clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign load_o = load_q;
  assign byte_o = byte_q;

  // R7
  pflag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(done_i));
  // R6
  prn_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(sel_i));
endmodule

// File: rtl/cterm_intr.sv
module cterm_intr (
  input  logic clk,
  input  logic rst,
  input  logic mclr_i,
  input  logic ack_i,
  input  logic event_i,
  input  logic ion_i,
  input  logic iof_i,
  output logic ie_o
);
  logic ie_q, pend_q;
  logic ie_d, pend_d;

  always_comb begin
    ie_d   = ie_q;
    pend_d = pend_q;
    if (event_i && pend_q) begin
      ie_d   = 1'b1;
      pend_d = 1'b0;
    end
    if (ion_i && !ie_d) pend_d = 1'b1;
    if (iof_i || mclr_i || ack_i) begin
      ie_d   = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      pend_q <= pend_d;
    end
  end

  assign ie_o = ie_q;

  // R9
  ie_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ie_q) |-> $past(pend_q) && $past(event_i));
  // R12
  ack_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ack_i) |-> !ie_q && !pend_q);
  // R10
  iof_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(iof_i) |-> !ie_q);
endmodule

// File: rtl/con_term_ctrl.sv
module con_term_ctrl
  import cterm_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int DATA_W  = 8,
  parameter int DEV_W   = 6,
  parameter int KBD_DEV = 3,
  parameter int PRN_DEV = 4,
  parameter int INT_DEV = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr_i,
  input  logic              iot_valid_i,
  input  logic [WORD_W-1:0] iot_word_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              instr_done_i,
  input  logic              int_ack_i,
  input  logic              kbd_strobe_i,
  input  logic [DATA_W-1:0] kbd_char_i,
  input  logic              prn_done_i,
  output logic              done_o,
  output logic              skip_o,
  output logic [WORD_W-1:0] acc_o,
  output logic              prn_load_o,
  output logic [DATA_W-1:0] prn_byte_o,
  output logic              irq_o
);
  cterm_dec_t        dec;
  logic              kflag, pflag, ie;
  logic [WORD_W-1:0] kacc;
  logic              skip_d;

  cterm_decode #(
    .WORD_W(WORD_W), .DEV_W(DEV_W),
    .KBD_DEV(KBD_DEV), .PRN_DEV(PRN_DEV), .INT_DEV(INT_DEV)
  ) dec_i (
    .valid_i(iot_valid_i), .word_i(iot_word_i), .dec_o(dec)
  );

  cterm_kbd #(.WORD_W(WORD_W), .DATA_W(DATA_W)) kbd_i (
    .clk(clk), .rst(rst), .mclr_i(mclr_i),
    .strobe_i(kbd_strobe_i), .char_i(kbd_char_i),
    .sel_i(dec.kbd), .clr_i(dec.clr), .rd_i(dec.xfr),
    .acc_i(acc_i), .flag_o(kflag), .acc_o(kacc)
  );

  cterm_prn #(.DATA_W(DATA_W)) prn_i (
    .clk(clk), .rst(rst), .mclr_i(mclr_i), .done_i(prn_done_i),
    .sel_i(dec.prn), .clr_i(dec.clr), .xfr_i(dec.xfr),
    .data_i(acc_i[DATA_W-1:0]),
    .flag_o(pflag), .load_o(prn_load_o), .byte_o(prn_byte_o)
  );

  cterm_intr intr_i (
    .clk(clk), .rst(rst), .mclr_i(mclr_i), .ack_i(int_ack_i),
    .event_i(dec.valid || instr_done_i),
    .ion_i(dec.ion), .iof_i(dec.iof), .ie_o(ie)
  );

  assign skip_d = dec.skp && ((dec.kbd && kflag) || (dec.prn && pflag));

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      skip_o <= 1'b0;
      acc_o  <= '0;
    end else begin
      done_o <= dec.valid;
      skip_o <= dec.valid && skip_d;
      if (dec.valid) acc_o <= kacc;
    end
  end

  assign irq_o = ie && (kflag || pflag);

  // R13
  mclr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mclr_i) |-> !irq_o && !kflag && !pflag);
  // R1
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(iot_valid_i));
endmodule

// File: tb/con_term_ctrl_tb_top.sv
module con_term_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst, mclr, valid, idone, ack, kst, pdone;
  logic [11:0] word, acc_in;
  logic [7:0]  kch;
  logic        done_o, skip_o, prn_load_o, irq_o;
  logic [11:0] acc_o;
  logic [7:0]  prn_byte_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  bit       m_kf, m_pf, m_ie, m_pend;
  bit [7:0] m_kbuf;
  bit       e_done, e_skip, e_ld, e_irq;
  bit [11:0] e_acc;
  bit [7:0]  e_byte;

  always #5 clk = ~clk;

  con_term_ctrl dut_i (
    .clk(clk), .rst(rst), .mclr_i(mclr), .iot_valid_i(valid),
    .iot_word_i(word), .acc_i(acc_in), .instr_done_i(idone),
    .int_ack_i(ack), .kbd_strobe_i(kst), .kbd_char_i(kch),
    .prn_done_i(pdone), .done_o(done_o), .skip_o(skip_o), .acc_o(acc_o),
    .prn_load_o(prn_load_o), .prn_byte_o(prn_byte_o), .irq_o(irq_o)
  );

  function automatic logic [11:0] iot(input int dev, input int op);
    return {3'b110, 6'(dev), 3'(op)};
  endfunction

  task automatic model();
    bit is_iot, kb, pr, ion, iof, ev, ie_n, pend_n;
    bit [5:0] dev;
    bit [2:0] op;
    bit [11:0] a;
    if (rst) begin
      m_kf = 0; m_pf = 0; m_ie = 0; m_pend = 0; m_kbuf = 0;
      e_done = 0; e_skip = 0; e_ld = 0; e_acc = 0; e_byte = 0; e_irq = 0;
      return;
    end
    is_iot = valid && (word[11:9] == 3'b110);
    dev = word[8:3];
    op  = word[2:0];
    kb  = is_iot && dev == 3;
    pr  = is_iot && dev == 4;
    ion = is_iot && dev == 0 && op == 3'd1;
    iof = is_iot && dev == 0 && op == 3'd2;
    a = acc_in;
    if (kb && op[1]) a = 0;
    if (kb && op[2]) a[7:0] = a[7:0] | m_kbuf;
    e_done = is_iot;
    e_skip = is_iot && op[0] && ((kb && m_kf) || (pr && m_pf));
    if (is_iot) e_acc = a;
    e_ld = pr && op[2];
    if (e_ld) e_byte = acc_in[7:0];
    if (kst) m_kbuf = kch;
    if (mclr) m_kf = 0; else if (kst) m_kf = 1; else if (kb && op[1]) m_kf = 0;
    if (mclr) m_pf = 0; else if (pdone) m_pf = 1; else if (pr && op[1]) m_pf = 0;
    ev = is_iot || idone;
    ie_n = m_ie; pend_n = m_pend;
    if (ev && m_pend) begin ie_n = 1; pend_n = 0; end
    if (ion && !ie_n) pend_n = 1;
    if (iof || mclr || ack) begin ie_n = 0; pend_n = 0; end
    m_ie = ie_n; m_pend = pend_n;
    e_irq = m_ie && (m_kf || m_pf);
  endtask

  task automatic cmp1(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    cmp1(tag, "done", done_o, e_done);
    cmp1(tag, "skip", skip_o, e_skip);
    cmp1(tag, "acc", acc_o, e_acc);
    cmp1(tag, "prn_load", prn_load_o, e_ld);
    cmp1(tag, "prn_byte", prn_byte_o, e_byte);
    cmp1(tag, "irq", irq_o, e_irq);
    valid = 0; word = 0; acc_in = 0; idone = 0; ack = 0;
    kst = 0; kch = 0; pdone = 0; mclr = 0;
  endtask

  task automatic ins(input logic [11:0] w, input logic [11:0] a, input string tag);
    valid = 1; word = w; acc_in = a;
    step(tag);
  endtask

  initial begin
    rst = 1; mclr = 0; valid = 0; word = 0; acc_in = 0; idone = 0;
    ack = 0; kst = 0; kch = 0; pdone = 0;
    @(negedge clk);
    step("R13");                       // reset state
    rst = 0;
    step("R1");
    ins(iot(3, 1), 12'h123, "R2");     // skip test, flag clear
    kst = 1; kch = 8'h5A; step("R5");  // character arrives
    ins(iot(3, 1), 12'h000, "R2");     // skip test, flag set
    ins(iot(3, 6), 12'hA33, "R4");     // clear then load -> 05A
    ins(iot(3, 1), 12'h000, "R3");     // flag now clear
    ins(iot(3, 4), 12'h801, "R4");     // OR only -> 85B
    ins(iot(3, 2), 12'hFFF, "R3");     // clear acc
    valid = 1; word = iot(3, 2); kst = 1; kch = 8'h11; step("R5");
    ins(iot(3, 1), 12'h000, "R5");     // arrival won
    ins(iot(4, 6), 12'h3C7, "R6");     // print C7, acc kept
    ins(iot(4, 1), 12'h000, "R7");     // printer flag not set by load
    pdone = 1; step("R7");
    ins(iot(4, 1), 12'h000, "R7");     // now skips
    valid = 1; word = iot(4, 2); pdone = 1; step("R7");
    ins(iot(4, 1), 12'h000, "R7");
    ins(iot(3, 0), 12'h456, "R8");
    ins(iot(7, 7), 12'h789, "R8");
    ins(iot(0, 4), 12'h0AB, "R8");
    ins(12'h5FF, 12'h321, "R1");       // not an I/O transfer word
    ins(iot(0, 1), 12'h000, "R9");     // turn on, pending
    step("R9");                        // no completion yet
    idone = 1; step("R9");             // completion -> on
    step("R11");
    ack = 1; step("R12");
    ins(iot(0, 1), 12'h000, "R10");
    ins(iot(0, 2), 12'h000, "R10");    // off cancels pending
    idone = 1; step("R10");
    ins(iot(0, 1), 12'h000, "R12");
    ack = 1; step("R12");
    idone = 1; step("R12");
    ins(iot(0, 1), 12'h000, "R11");
    ins(iot(3, 2), 12'h000, "R11");    // completion; clears kbd flag
    ins(iot(4, 2), 12'h000, "R11");    // last flag cleared -> irq low
    pdone = 1; step("R11");
    mclr = 1; step("R13");
    ins(iot(4, 1), 12'h000, "R13");
    idone = 1; step("R13");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule